// File: doc/BRIEF.md
# Serial Radix-4 Booth Multiplier

This block multiplies two signed two's-complement operands of N bits (N even, default 8) over several clock cycles and returns a signed 2N-bit product. Each iteration recodes two multiplier bits together with the bit just below them. The recoded digit picks an addend of zero, the multiplicand or twice the multiplicand, and may negate it. The multiplier therefore finishes in N/2 iterations rather than N.

Storage is kept small. The growing product and the multiplier bits not yet used share one 2N+1-bit shift register, whose lowest bit is a zero placed below the multiplier at load time. Only the upper field of that register passes through an N+1-bit adder/subtractor. The lower field shifts along without any arithmetic. The sign bit the narrow adder cannot hold is recovered from the operand signs and the carry out. After each add, the register shifts right arithmetically by two places.

To use the block, present both operands and pulse `start` while it is idle. Then wait for the one-cycle `done` pulse. The product stays on `product` until the next accepted start.

Top module: `booth_serial_mul`

## Requirements
- R1: While `rst` is high at a clock edge, and after it, `busy`, `done` and `product` are all zero.
- R2: A start seen at an idle edge sets `busy` after that edge. `done` rises exactly N/2 edges after the accepting edge, and `busy` falls at that same edge.
- R3: Each iteration takes a 3-bit window (two multiplier bits and the bit below them, which is zero for the first window) and applies: 000 and 111 add zero; 001 and 010 add A; 011 adds 2A; 100 subtracts 2A; 101 and 110 subtract A.
- R4: `product` equals the exact signed product of `mcand` and `mplier` for every operand pair, including -2^(N-1) times -2^(N-1) and the pairs where ±2A reaches ±2^N.
- R5: A multiplicand of 15 and a multiplier of 9 give a product of 135.
- R6: `done` is high for exactly one cycle per operation.
- R7: After `done`, `product` stays unchanged, whatever happens on the operand inputs, until a new start is accepted.
- R8: A `start` pulse while `busy` is high is ignored. The operation in flight keeps its operands and its timing.
- R9: A `start` presented in the cycle where `done` is high is accepted, and a new operation begins at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a multiplication when the block is idle |
| mcand | input | N | Signed multiplicand, sampled on the accepting edge |
| mplier | input | N | Signed multiplier, sampled on the accepting edge |
| busy | output | 1 | High while iterations are in progress |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2N | Signed product, held until the next start |

## Verification
The bench targets the operand pairs where the narrow adder's true sum no longer fits its N+1 bits: a most-negative multiplicand paired with multipliers whose windows request -2A. A design that keeps only the adder's own top bit as the sign would flip the sign of the accumulator there and return a badly wrong product. Each window code is reached through chosen multipliers. A swapped table entry or a first window that does not start from zero would move odd and even multipliers off their exact results. The bench also counts the latency, injects start pulses both mid-operation and in the `done` cycle, and changes the inputs while the block is idle. These tests expose an off-by-one iteration count, a restart that clobbers the operands, and a product that drifts after completion.

// File: rtl/booth_pkg.sv
package booth_pkg;

    // Recoded Booth digit: magnitude select plus negate flag
    typedef struct packed {
        logic one;   // magnitude is |A|
        logic two;   // magnitude is 2|A|
        logic neg;   // subtract instead of add
    } booth_ctl_t;

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
    import booth_pkg::*;
(
    input  logic [2:0]  win,
    output booth_ctl_t  ctl
);

    always_comb begin
        ctl = '0;
        unique case (win)
            3'b001, 3'b010: ctl.one = 1'b1;
            3'b011:         ctl.two = 1'b1;
            3'b100: begin
                ctl.two = 1'b1;
                ctl.neg = 1'b1;
            end
            3'b101, 3'b110: begin
                ctl.one = 1'b1;
                ctl.neg = 1'b1;
            end
            default:        ctl = '0;
        endcase
    end

    always_comb begin
        if (!$isunknown(win)) begin
            // R3
            sel_onehot_chk: assert ($onehot0({ctl.one, ctl.two}));
            // R3
            neg_nonzero_chk: assert (!ctl.neg || ctl.one || ctl.two);
        end
    end

endmodule

// File: rtl/booth_pp_sel.sv
module booth_pp_sel
    import booth_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] mcand,
    input  booth_ctl_t   ctl,
    output logic [N:0]   mag
);

    logic [N:0] a_ext;
    logic [N:0] a_dbl;

    always_comb begin
        a_ext = {mcand[N-1], mcand};
        a_dbl = {mcand, 1'b0};
        mag   = '0;
        if (ctl.one) mag = a_ext;
        if (ctl.two) mag = a_dbl;
    end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub #(
    parameter int W = 9
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] opnd,
    input  logic         neg,
    output logic [W-1:0] sum,
    output logic         sign_ext
);

    logic [W-1:0] opx;
    logic [W:0]   raw;

    always_comb begin
        opx      = neg ? ~opnd : opnd;
        raw      = {1'b0, acc} + {1'b0, opx} + {{W{1'b0}}, neg};
        sum      = raw[W-1:0];
        // sign of the W+1-bit true result from extended operand signs
        sign_ext = acc[W-1] ^ opx[W-1] ^ raw[W];
    end

endmodule

// File: rtl/booth_serial_mul.sv
module booth_serial_mul
    import booth_pkg::*;
#(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [N-1:0]   mcand,
    input  logic [N-1:0]   mplier,
    output logic           busy,
    output logic           done,
    output logic [2*N-1:0] product
);

    localparam int MW    = 2 * N + 1;
    localparam int AW    = N + 1;
    localparam int STEPS = N / 2;
    localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic [N-1:0]  mcand;
        logic [MW-1:0] acc;
    } state_t;

    state_t st_q, st_d;

    booth_ctl_t    ctl;
    logic [AW-1:0] upper;
    logic [AW-1:0] mag;
    logic [AW-1:0] sum;
    logic          sgn;

    assign upper = {st_q.acc[MW-1], st_q.acc[MW-1:N+1]};

    booth_recoder u_rec (
        .win (st_q.acc[2:0]),
        .ctl (ctl)
    );

    booth_pp_sel #(.N(N)) u_sel (
        .mcand (st_q.mcand),
        .ctl   (ctl),
        .mag   (mag)
    );

    booth_addsub #(.W(AW)) u_add (
        .acc      (upper),
        .opnd     (mag),
        .neg      (ctl.neg),
        .sum      (sum),
        .sign_ext (sgn)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            // add into upper field, then arithmetic shift right by two
            st_d.acc = {sgn, sum, st_q.acc[N:2]};
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.cnt  = '0;
            end
        end else if (start) begin
            st_d.busy  = 1'b1;
            st_d.cnt   = '0;
            st_d.mcand = mcand;
            st_d.acc   = {{N{1'b0}}, mplier, 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign product = st_q.acc[MW-1:1];

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);
    // R2
    finish_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && st_q.cnt == LAST) |=> (done && !busy));
    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> (st_q.mcand == $past(st_q.mcand)));
    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(product));

endmodule

// File: tb/booth_serial_mul_bench.sv
module booth_serial_mul_bench;

    localparam int N     = 8;
    localparam int STEPS = N / 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [N-1:0]   mcand = '0;
    logic [N-1:0]   mplier = '0;
    logic           busy;
    logic           done;
    logic [2*N-1:0] product;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // {mcand, mplier}
    localparam logic [15:0] VEC [14] = '{
        16'h0F09, 16'hFFFF, 16'h7F7F, 16'h8080, 16'h807F, 16'h7F80, 16'h8002,
        16'h8001, 16'h03F9, 16'h552A, 16'h9C39, 16'h0700, 16'h00FB, 16'h0101
    };

    booth_serial_mul #(.N(N)) u_booth_serial_mul (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .mcand   (mcand),
        .mplier  (mplier),
        .busy    (busy),
        .done    (done),
        .product (product)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [2*N-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
        logic signed [2*N-1:0] ea, eb;
        ea = $signed({{N{a[N-1]}}, a});
        eb = $signed({{N{b[N-1]}}, b});
        return ea * eb;
    endfunction

    // called mid-cycle; returns mid-cycle after the accepting edge
    task automatic launch(input logic [N-1:0] a, input logic [N-1:0] b);
        mcand  = a;
        mplier = b;
        start  = 1'b1;
        @(posedge clk); #1;
        start  = 1'b0;
    endtask

    task automatic wait_done(output int lat);
        lat = 0;
        while (!done && lat < 20) begin
            @(posedge clk); #1;
            lat++;
        end
    endtask

    task automatic run_one(input logic [N-1:0] a, input logic [N-1:0] b, input string req);
        int lat;
        logic [2*N-1:0] exp;
        exp = ref_mul(a, b);
        @(negedge clk);
        launch(a, b);
        check(busy == 1'b1, "R2 busy after accept", longint'(busy), 1);
        wait_done(lat);
        check(lat == STEPS, "R2 latency", lat, STEPS);
        check(product == exp, req, longint'($signed(product)), longint'($signed(exp)));
    endtask

    initial begin
        int lat;
        logic [2*N-1:0] held;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check(busy == 0 && done == 0, "R1 flags in reset", longint'({busy, done}), 0);
        check(product == 0, "R1 product in reset", longint'(product), 0);
        @(negedge clk);
        rst = 1'b0;

        // R5 worked example
        run_one(8'd15, 8'd9, "R5 15x9");

        // R6 one-cycle done, R7 hold while inputs change
        held = product;
        mcand = 8'hA5; mplier = 8'h3C;
        @(posedge clk); #1;
        check(done == 1'b0, "R6 done single cycle", longint'(done), 0);
        check(busy == 1'b0, "R8 no spurious restart", longint'(busy), 0);
        repeat (5) begin
            mcand = mcand + 8'd7;
            @(posedge clk); #1;
        end
        check(product == held, "R7 product held", longint'(product), longint'(held));

        // R4 / R3 table of vectors: every window code and the extremes
        foreach (VEC[i]) run_one(VEC[i][15:8], VEC[i][7:0], "R4 vector");

        // R4 / R3 sweep over spread operands
        for (int i = 0; i < 40; i++) begin
            run_one(8'(i * 73 + 11), 8'(i * 151 + 200), "R3 sweep");
        end

        // R8 start while busy is ignored
        @(negedge clk);
        launch(8'd5, 8'hFD);
        @(posedge clk); #1;
        mcand = 8'd99; mplier = 8'd77; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        wait_done(lat);
        check(lat + 2 == STEPS, "R8 latency kept", lat + 2, STEPS);
        check(product == ref_mul(8'd5, 8'hFD), "R8 operands kept",
              longint'($signed(product)), -15);

        // R9 start in the done cycle is accepted
        launch(8'hF0, 8'd6);
        check(busy == 1'b1, "R9 accepted on done", longint'(busy), 1);
        wait_done(lat);
        check(lat == STEPS, "R9 latency", lat, STEPS);
        check(product == ref_mul(8'hF0, 8'd6), "R9 result",
              longint'($signed(product)), -96);

        // R1 reset during an operation
        @(negedge clk);
        launch(8'd15, 8'd9);
        rst = 1'b1;
        @(posedge clk); #1;
        check(busy == 0 && done == 0, "R1 flags after mid reset", longint'({busy, done}), 0);
        check(product == 0, "R1 product after mid reset", longint'(product), 0);
        rst = 1'b0;
        @(posedge clk); #1;
        check(busy == 0, "R1 stays idle", longint'(busy), 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule